// File: doc/BRIEF.md
# Window Pixel Transfer Engine

This block takes a stream of bytes arriving at a display-memory data port and places them into a rectangular window of a frame buffer. The window is given by inclusive start and end coordinates. The pixel size comes from a 4-bit input-format code. For every accepted byte the engine issues one write request. The request carries a pixel address, a byte lane within the pixel and the data byte. The window is walked in raster order.

A transfer is set up when the source-select strobe fires. It is also set up without a strobe when a data byte arrives and nothing is pending. Setup computes the expected byte count and checks that the configuration is legal. An illegal setup raises an error flag and discards the incoming bytes. When the last byte of a window is written, the engine commits the window. It then widens a running dirty bounding box, so that display refresh logic can copy only the changed region. The refresh side empties the box with a clear input once it has used it.

Top module: `wxfer_engine`

## Requirements
- R1: The format code sets the bytes per pixel as follows. Code 1 gives 2 bytes. Codes 2 and 3 give 3 bytes. Codes 5 and 6 give 4 bytes. Every other code gives 0 bytes, which makes the setup illegal.
- R2: A setup is rejected when any of these holds: the source select is above 3, the byte count per pixel is 0, `cfg_x1 < cfg_x0`, or `cfg_y1 < cfg_y0`. On the next cycle a rejected setup raises `setup_err`, cancels any pending transfer and produces no write. An accepted setup clears `setup_err`.
- R3: An accepted setup expects bytes-per-pixel × (x1−x0+1) × (y1−y0+1) bytes. `busy` is high exactly while some of those bytes are still outstanding.
- R4: `setup_stb` always starts a new setup from the current configuration and replaces any pending transfer. A data byte that arrives while nothing is pending first runs setup. If that setup is accepted, the byte becomes the first byte of the new transfer. The same holds for a byte that arrives together with `setup_stb`.
- R5: Each accepted byte produces a write request one cycle later. In that request `wr_data` is the byte and `wr_addr` = (y0+row)×DISP_W + (x0+col). `wr_lane` counts 0 to bpp−1 within a pixel. Lanes advance first, then columns from left to right, then rows from top to bottom.
- R6: `commit` pulses in the same cycle as the write request for the final byte of a window, and `busy` is low in that cycle.
- R7: When the dirty box is empty, a commit sets it to min = (x0, y0) and max = (x0+w, y0+h), where max is exclusive, and raises `dirty_valid`. When the box is not empty, a commit lowers the minimum and raises the maximum so that the box covers both areas.
- R8: `dirty_clr` empties the box on the next cycle: `dirty_valid` goes to 0 and all four coordinates go to 0. If a commit happens in the same cycle as the clear, the box becomes exactly that window.
- R9: `rot_path` goes high when the rotation select latched at the last accepted setup is non-zero.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 4 | Input format code |
| cfg_src | input | 3 | Data source select |
| cfg_rot | input | 2 | Rotation select |
| cfg_x0 | input | 10 | Window start column |
| cfg_y0 | input | 10 | Window start row |
| cfg_x1 | input | 10 | Window end column (inclusive) |
| cfg_y1 | input | 10 | Window end row (inclusive) |
| setup_stb | input | 1 | Source-select write; starts a setup |
| dp_valid | input | 1 | Data-port byte strobe |
| dp_byte | input | 8 | Data-port byte |
| dirty_clr | input | 1 | Empty the dirty box |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Pixel address |
| wr_lane | output | 2 | Byte lane within the pixel |
| wr_data | output | 8 | Byte to write |
| commit | output | 1 | Window completed |
| busy | output | 1 | Transfer bytes outstanding |
| setup_err | output | 1 | Last setup rejected |
| rot_path | output | 1 | Rotated line path selected |
| dirty_valid | output | 1 | Dirty box non-empty |
| dirty_x0 | output | 11 | Dirty box minimum column |
| dirty_y0 | output | 11 | Dirty box minimum row |
| dirty_x1 | output | 11 | Dirty box maximum column (exclusive) |
| dirty_y1 | output | 11 | Dirty box maximum row (exclusive) |

## Verification
The transfer path is driven in several ways, and each one separates a different kind of error:
- Multi-row windows sent with idle gaps show whether lane, column and row advance in the right order.
- Auto-armed single-row transfers test the path where the first byte also arms the setup.
- A 1×1 window swept over all sixteen format codes checks the byte-count table.
- Each of the four rejection causes is tried, followed by stray bytes, to show that nothing leaks onto the write port.

A restart in the middle of a transfer checks that the new setup replaces the old one. Firing the strobe and a byte in the same cycle checks which of the two wins. Clears are sent on their own and also together with a final byte, which shows whether the box is reset or merged.

// File: rtl/wxfer_pkg.sv
package wxfer_pkg;

    localparam int COORD_W = 10;
    localparam int SPAN_W  = COORD_W + 1;
    localparam int BPP_W   = 3;
    localparam int LANE_W  = 2;
    localparam int LEN_W   = 2 * SPAN_W + BPP_W;
    localparam int SRC_MAX = 3;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [SPAN_W-1:0]  span_t;
    typedef logic [BPP_W-1:0]   bpp_t;
    typedef logic [LANE_W-1:0]  lane_t;
    typedef logic [LEN_W-1:0]   len_t;

    typedef enum logic [3:0] {
        FMT_PIX16   = 4'd1,
        FMT_PIX18_P = 4'd2,
        FMT_PIX24_P = 4'd3,
        FMT_PIX18_W = 4'd5,
        FMT_PIX24_W = 4'd6
    } fmt_e;

    typedef struct packed {
        coord_t x0;
        coord_t y0;
        span_t  w;
        span_t  h;
        bpp_t   bpp;
        logic   rot;
    } win_t;

    function automatic bpp_t bytes_per_pixel(logic [3:0] code);
        case (fmt_e'(code))
            FMT_PIX16:                bytes_per_pixel = bpp_t'(2);
            FMT_PIX18_P, FMT_PIX24_P: bytes_per_pixel = bpp_t'(3);
            FMT_PIX18_W, FMT_PIX24_W: bytes_per_pixel = bpp_t'(4);
            default:                  bytes_per_pixel = '0;
        endcase
    endfunction

    function automatic span_t extent(coord_t lo, coord_t hi);
        extent = span_t'(hi) - span_t'(lo) + span_t'(1);
    endfunction

endpackage

// File: rtl/wxfer_setup.sv
module wxfer_setup
    import wxfer_pkg::*;
(
    input  logic [3:0] fmt,
    input  logic [2:0] src,
    input  logic [1:0] rot,
    input  coord_t     x0,
    input  coord_t     y0,
    input  coord_t     x1,
    input  coord_t     y1,
    output win_t       win,
    output logic       legal,
    output len_t       len
);

    always_comb begin
        win.x0  = x0;
        win.y0  = y0;
        win.w   = extent(x0, x1);
        win.h   = extent(y0, y1);
        win.bpp = bytes_per_pixel(fmt);
        win.rot = |rot;
        legal   = (src <= 3'(SRC_MAX)) && (win.bpp != '0) && (x1 >= x0) && (y1 >= y0);
        len     = len_t'(win.bpp) * len_t'(win.w) * len_t'(win.h);
    end

endmodule

// File: rtl/wxfer_walker.sv
module wxfer_walker
    import wxfer_pkg::*;
#(
    parameter int DISP_W = 320,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              legal,
    input  win_t              win_in,
    input  len_t              len_in,
    input  logic              dp_valid,
    input  logic [7:0]        dp_byte,
    output logic              pending,
    output logic              setup_err,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output lane_t             wr_lane,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic              rot_path,
    output logic              commit_now,
    output win_t              commit_win
);

    localparam logic [ADDR_W-1:0] ROW_STRIDE = ADDR_W'(DISP_W);

    win_t  cur_win;
    len_t  remaining;
    lane_t lane;
    span_t col;
    span_t row;

    logic  take_new;
    logic  accept;
    win_t  eff_win;
    len_t  eff_rem;
    lane_t eff_lane;
    span_t eff_col;
    span_t eff_row;
    logic  last_lane;
    logic  last_col;
    lane_t nxt_lane;
    span_t nxt_col;
    span_t nxt_row;
    logic [ADDR_W-1:0] pix_addr;

    always_comb begin
        take_new = arm && legal;
        accept   = dp_valid && (arm ? legal : (remaining != '0));
        eff_win  = take_new ? win_in : cur_win;
        eff_rem  = take_new ? len_in : remaining;
        eff_lane = take_new ? '0 : lane;
        eff_col  = take_new ? '0 : col;
        eff_row  = take_new ? '0 : row;

        last_lane = ({1'b0, eff_lane} == (eff_win.bpp - bpp_t'(1)));
        last_col  = (eff_col == (eff_win.w - span_t'(1)));
        nxt_lane  = last_lane ? '0 : eff_lane + lane_t'(1);
        nxt_col   = eff_col;
        nxt_row   = eff_row;
        if (last_lane) begin
            if (last_col) begin
                nxt_col = '0;
                nxt_row = eff_row + span_t'(1);
            end else begin
                nxt_col = eff_col + span_t'(1);
            end
        end

        pix_addr = ADDR_W'(span_t'(eff_win.y0) + eff_row) * ROW_STRIDE
                 + ADDR_W'(span_t'(eff_win.x0) + eff_col);

        commit_now = accept && (eff_rem == len_t'(1));
        commit_win = eff_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_win   <= '0;
            remaining <= '0;
            lane      <= '0;
            col       <= '0;
            row       <= '0;
            setup_err <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_lane   <= '0;
            wr_data   <= '0;
            commit    <= 1'b0;
        end else begin
            wr_valid <= accept;
            commit   <= commit_now;
            if (arm) begin
                setup_err <= !legal;
            end
            if (take_new) begin
                cur_win <= win_in;
            end
            if (accept) begin
                wr_addr   <= pix_addr;
                wr_lane   <= eff_lane;
                wr_data   <= dp_byte;
                remaining <= eff_rem - len_t'(1);
                lane      <= nxt_lane;
                col       <= nxt_col;
                row       <= nxt_row;
            end else if (take_new) begin
                remaining <= len_in;
                lane      <= '0;
                col       <= '0;
                row       <= '0;
            end else if (arm) begin
                remaining <= '0;
            end
        end
    end

    assign pending  = (remaining != '0);
    assign rot_path = cur_win.rot;

endmodule

// File: rtl/wxfer_dirty.sv
module wxfer_dirty
    import wxfer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   upd,
    input  coord_t x0,
    input  coord_t y0,
    input  span_t  w,
    input  span_t  h,
    output logic   valid,
    output span_t  lo_x,
    output span_t  lo_y,
    output span_t  hi_x,
    output span_t  hi_y
);

    span_t new_lo_x;
    span_t new_lo_y;
    span_t new_hi_x;
    span_t new_hi_y;
    logic  fresh;

    always_comb begin
        new_lo_x = span_t'(x0);
        new_lo_y = span_t'(y0);
        new_hi_x = span_t'(x0) + w;
        new_hi_y = span_t'(y0) + h;
        fresh    = !valid || clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            lo_x  <= '0;
            lo_y  <= '0;
            hi_x  <= '0;
            hi_y  <= '0;
        end else if (upd) begin
            valid <= 1'b1;
            lo_x  <= (fresh || new_lo_x < lo_x) ? new_lo_x : lo_x;
            lo_y  <= (fresh || new_lo_y < lo_y) ? new_lo_y : lo_y;
            hi_x  <= (fresh || new_hi_x > hi_x) ? new_hi_x : hi_x;
            hi_y  <= (fresh || new_hi_y > hi_y) ? new_hi_y : hi_y;
        end else if (clear) begin
            valid <= 1'b0;
            lo_x  <= '0;
            lo_y  <= '0;
            hi_x  <= '0;
            hi_y  <= '0;
        end
    end

endmodule

// File: rtl/wxfer_engine.sv
module wxfer_engine
    import wxfer_pkg::*;
#(
    parameter int DISP_W = 320,
    parameter int DISP_H = 240,
    localparam int ADDR_W = $clog2(DISP_W * DISP_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_fmt,
    input  logic [2:0]        cfg_src,
    input  logic [1:0]        cfg_rot,
    input  coord_t            cfg_x0,
    input  coord_t            cfg_y0,
    input  coord_t            cfg_x1,
    input  coord_t            cfg_y1,
    input  logic              setup_stb,
    input  logic              dp_valid,
    input  logic [7:0]        dp_byte,
    input  logic              dirty_clr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output lane_t             wr_lane,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic              busy,
    output logic              setup_err,
    output logic              rot_path,
    output logic              dirty_valid,
    output span_t             dirty_x0,
    output span_t             dirty_y0,
    output span_t             dirty_x1,
    output span_t             dirty_y1
);

    win_t setup_win;
    logic setup_ok;
    len_t setup_len;
    logic arm;
    logic commit_now;
    win_t commit_win;

    assign arm = setup_stb || (dp_valid && !busy);

    wxfer_setup u_setup (
        .fmt   (cfg_fmt),
        .src   (cfg_src),
        .rot   (cfg_rot),
        .x0    (cfg_x0),
        .y0    (cfg_y0),
        .x1    (cfg_x1),
        .y1    (cfg_y1),
        .win   (setup_win),
        .legal (setup_ok),
        .len   (setup_len)
    );

    wxfer_walker #(
        .DISP_W (DISP_W),
        .ADDR_W (ADDR_W)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .legal      (setup_ok),
        .win_in     (setup_win),
        .len_in     (setup_len),
        .dp_valid   (dp_valid),
        .dp_byte    (dp_byte),
        .pending    (busy),
        .setup_err  (setup_err),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_lane    (wr_lane),
        .wr_data    (wr_data),
        .commit     (commit),
        .rot_path   (rot_path),
        .commit_now (commit_now),
        .commit_win (commit_win)
    );

    wxfer_dirty u_dirty (
        .clk   (clk),
        .rst   (rst),
        .clear (dirty_clr),
        .upd   (commit_now),
        .x0    (commit_win.x0),
        .y0    (commit_win.y0),
        .w     (commit_win.w),
        .h     (commit_win.h),
        .valid (dirty_valid),
        .lo_x  (dirty_x0),
        .lo_y  (dirty_y0),
        .hi_x  (dirty_x1),
        .hi_y  (dirty_y1)
    );

endmodule

// File: rtl/wxfer_engine_chk.sv
module wxfer_engine_chk
    import wxfer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cfg_src,
    input logic       setup_stb,
    input logic       dp_valid,
    input logic [7:0] dp_byte,
    input logic       dirty_clr,
    input logic       wr_valid,
    input logic [7:0] wr_data,
    input logic       commit,
    input logic       busy,
    input logic       setup_err,
    input logic       dirty_valid,
    input span_t      dirty_x0,
    input span_t      dirty_y0,
    input span_t      dirty_x1,
    input span_t      dirty_y1
);

    AST_REJECT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (setup_stb && cfg_src > 3'(SRC_MAX)) |=> (setup_err && !busy && !wr_valid)); // R2

    AST_WRITE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(dp_valid) && wr_data == $past(dp_byte))); // R5

    AST_COMMIT_ENDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        commit |-> (wr_valid && !busy)); // R6

    AST_COMMIT_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
        commit |-> dirty_valid); // R7

    AST_DIRTY_ORDERED: assert property (@(posedge clk) disable iff (rst)
        dirty_valid |-> (dirty_x0 < dirty_x1 && dirty_y0 < dirty_y1)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        dirty_clr |=> (commit || !dirty_valid)); // R8

endmodule

bind wxfer_engine wxfer_engine_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_src     (cfg_src),
    .setup_stb   (setup_stb),
    .dp_valid    (dp_valid),
    .dp_byte     (dp_byte),
    .dirty_clr   (dirty_clr),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .commit      (commit),
    .busy        (busy),
    .setup_err   (setup_err),
    .dirty_valid (dirty_valid),
    .dirty_x0    (dirty_x0),
    .dirty_y0    (dirty_y0),
    .dirty_x1    (dirty_x1),
    .dirty_y1    (dirty_y1)
);

// File: tb/wxfer_engine_tb_top.sv
module wxfer_engine_tb_top;
    import wxfer_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 320;
    localparam int AW         = $clog2(320 * 240);
    localparam int WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cfg_fmt = '0;
    logic [2:0]    cfg_src = '0;
    logic [1:0]    cfg_rot = '0;
    coord_t        cfg_x0 = '0, cfg_y0 = '0, cfg_x1 = '0, cfg_y1 = '0;
    logic          setup_stb = 1'b0;
    logic          dp_valid = 1'b0;
    logic [7:0]    dp_byte = '0;
    logic          dirty_clr = 1'b0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    lane_t         wr_lane;
    logic [7:0]    wr_data;
    logic          commit, busy, setup_err, rot_path, dirty_valid;
    span_t         dirty_x0, dirty_y0, dirty_x1, dirty_y1;

    int total = 0;
    int bad   = 0;

    wxfer_engine dut_i (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_src(cfg_src), .cfg_rot(cfg_rot),
        .cfg_x0(cfg_x0), .cfg_y0(cfg_y0), .cfg_x1(cfg_x1), .cfg_y1(cfg_y1),
        .setup_stb(setup_stb), .dp_valid(dp_valid), .dp_byte(dp_byte), .dirty_clr(dirty_clr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_data(wr_data),
        .commit(commit), .busy(busy), .setup_err(setup_err), .rot_path(rot_path),
        .dirty_valid(dirty_valid), .dirty_x0(dirty_x0), .dirty_y0(dirty_y0),
        .dirty_x1(dirty_x1), .dirty_y1(dirty_y1)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int q_addr[$];
    int q_lane[$];
    bit started = 0;
    int e_wv = 0, e_addr = 0, e_lane = 0, e_data = 0, e_commit = 0;
    int e_busy = 0, e_err = 0, e_rot = 0;
    int e_dv = 0, e_dx0 = 0, e_dy0 = 0, e_dx1 = 0, e_dy1 = 0;
    int w_x0 = 0, w_y0 = 0, w_x1 = 0, w_y1 = 0;

    function automatic int model_bpp(int code);
        if (code == 1) return 2;
        if (code == 2 || code == 3) return 3;
        if (code == 5 || code == 6) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            started = 1;
            q_addr.delete();
            q_lane.delete();
            e_wv = 0; e_commit = 0; e_busy = 0; e_err = 0; e_rot = 0;
            e_dv = 0; e_dx0 = 0; e_dy0 = 0; e_dx1 = 0; e_dy1 = 0;
        end else begin
            bit arm_m;
            bit ok;
            int b;
            e_wv = 0;
            e_commit = 0;
            arm_m = setup_stb || (dp_valid && q_addr.size() == 0);
            if (arm_m) begin
                b  = model_bpp(int'(cfg_fmt));
                ok = (cfg_src <= 3) && (b != 0) && (cfg_x1 >= cfg_x0) && (cfg_y1 >= cfg_y0);
                e_err = ok ? 0 : 1;
                q_addr.delete();
                q_lane.delete();
                if (ok) begin
                    w_x0 = int'(cfg_x0); w_y0 = int'(cfg_y0);
                    w_x1 = int'(cfg_x1) + 1; w_y1 = int'(cfg_y1) + 1;
                    e_rot = (cfg_rot != 0) ? 1 : 0;
                    for (int yy = w_y0; yy < w_y1; yy++)
                        for (int xx = w_x0; xx < w_x1; xx++)
                            for (int ll = 0; ll < b; ll++) begin
                                q_addr.push_back(yy * DW + xx);
                                q_lane.push_back(ll);
                            end
                end
            end
            if (dp_valid && q_addr.size() != 0) begin
                e_wv = 1;
                e_addr = q_addr.pop_front();
                e_lane = q_lane.pop_front();
                e_data = int'(dp_byte);
                if (q_addr.size() == 0) begin
                    e_commit = 1;
                    if (e_dv == 0 || dirty_clr) begin
                        e_dx0 = w_x0; e_dy0 = w_y0; e_dx1 = w_x1; e_dy1 = w_y1;
                    end else begin
                        if (w_x0 < e_dx0) e_dx0 = w_x0;
                        if (w_y0 < e_dy0) e_dy0 = w_y0;
                        if (w_x1 > e_dx1) e_dx1 = w_x1;
                        if (w_y1 > e_dy1) e_dy1 = w_y1;
                    end
                    e_dv = 1;
                end else if (dirty_clr) begin
                    e_dv = 0; e_dx0 = 0; e_dy0 = 0; e_dx1 = 0; e_dy1 = 0;
                end
            end else if (dirty_clr) begin
                e_dv = 0; e_dx0 = 0; e_dy0 = 0; e_dx1 = 0; e_dy1 = 0;
            end
            e_busy = (q_addr.size() != 0) ? 1 : 0;
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            check("R5 wr_valid", int'(wr_valid), e_wv);
            if (e_wv != 0) begin
                check("R5 wr_addr", int'(wr_addr), e_addr);
                check("R5 wr_lane", int'(wr_lane), e_lane);
                check("R5 wr_data", int'(wr_data), e_data);
            end
            check("R6 commit", int'(commit), e_commit);
            check("R3 busy", int'(busy), e_busy);
            check("R2 setup_err", int'(setup_err), e_err);
            check("R9 rot_path", int'(rot_path), e_rot);
            check("R7 dirty_valid", int'(dirty_valid), e_dv);
            check("R8 dirty_x0", int'(dirty_x0), e_dx0);
            check("R8 dirty_y0", int'(dirty_y0), e_dy0);
            check("R7 dirty_x1", int'(dirty_x1), e_dx1);
            check("R7 dirty_y1", int'(dirty_y1), e_dy1);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_cfg(int fmt, int src, int rot, int x0, int y0, int x1, int y1);
        cfg_fmt = 4'(fmt); cfg_src = 3'(src); cfg_rot = 2'(rot);
        cfg_x0 = COORD_W'(x0); cfg_y0 = COORD_W'(y0);
        cfg_x1 = COORD_W'(x1); cfg_y1 = COORD_W'(y1);
    endtask

    task automatic strobe();
        @(negedge clk); setup_stb = 1'b1;
        @(negedge clk); setup_stb = 1'b0;
    endtask

    task automatic send(int n, int seed, int gap_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); dp_valid = 1'b1; dp_byte = 8'(seed + i * 7);
            if (gap_every != 0 && (i % gap_every) == gap_every - 1) begin
                @(negedge clk); dp_valid = 1'b0;
            end
        end
        @(negedge clk); dp_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 reset wr_valid", int'(wr_valid), 0);
        check("R10 reset busy", int'(busy), 0);
        check("R10 reset dirty_valid", int'(dirty_valid), 0);
        check("R10 reset setup_err", int'(setup_err), 0);

        // 2x2 window, 3 bytes per pixel, strobe armed, idle gaps
        set_cfg(2, 0, 0, 2, 3, 3, 4);
        strobe();
        check("R1 busy after fmt2 setup", int'(busy), 1);
        send(12, 8'h10, 5);
        idle(2);

        // R4: auto-arm from the first byte, 3x1 window, 2 bytes per pixel
        set_cfg(1, 1, 0, 10, 5, 12, 5);
        @(negedge clk); dp_valid = 1'b1; dp_byte = 8'hA5;
        @(negedge clk); dp_valid = 1'b0;
        check("R4 auto-armed byte written", int'(wr_valid), 1);
        send(5, 8'h20, 0);
        idle(2);

        // R9: rotation selected, 1x2 window, 4 bytes per pixel
        set_cfg(5, 2, 1, 0, 0, 0, 1);
        strobe();
        check("R9 rot_path after setup", int'(rot_path), 1);
        send(8, 8'h30, 3);
        idle(2);

        // R2: each rejection cause, with stray bytes
        set_cfg(1, 4, 0, 1, 1, 2, 2);
        strobe();
        send(2, 8'h40, 0);
        set_cfg(0, 0, 0, 1, 1, 2, 2);
        strobe();
        send(2, 8'h44, 0);
        set_cfg(3, 0, 0, 5, 1, 4, 2);
        strobe();
        send(1, 8'h48, 0);
        set_cfg(3, 0, 0, 1, 6, 2, 5);
        send(1, 8'h4C, 0);
        check("R2 still rejected", int'(setup_err), 1);
        set_cfg(1, 3, 0, 40, 50, 40, 50);
        send(2, 8'h50, 0);
        idle(2);

        // R4: restart mid-transfer, then a rejection cancels a pending one
        set_cfg(3, 0, 0, 5, 5, 6, 6);
        strobe();
        send(3, 8'h60, 0);
        set_cfg(6, 0, 0, 1, 1, 1, 1);
        strobe();
        send(4, 8'h70, 0);
        set_cfg(2, 0, 0, 8, 8, 9, 9);
        strobe();
        send(2, 8'h78, 0);
        set_cfg(2, 7, 0, 8, 8, 9, 9);
        strobe();
        check("R2 pending cancelled", int'(busy), 0);
        idle(2);

        // R8: clear alone, then clear on the final byte
        @(negedge clk); dirty_clr = 1'b1;
        @(negedge clk); dirty_clr = 1'b0;
        check("R8 clear empties box", int'(dirty_valid), 0);
        set_cfg(1, 0, 0, 20, 21, 20, 21);
        strobe();
        send(1, 8'h80, 0);
        set_cfg(1, 0, 0, 30, 31, 31, 31);
        strobe();
        send(3, 8'h84, 0);
        @(negedge clk); dp_valid = 1'b1; dirty_clr = 1'b1; dp_byte = 8'h8F;
        @(negedge clk); dp_valid = 1'b0; dirty_clr = 1'b0;
        check("R8 clear with commit gives window", int'(dirty_x0), 30);
        idle(2);

        // R4: strobe and byte in the same cycle
        set_cfg(2, 0, 0, 100, 200, 100, 200);
        @(negedge clk); setup_stb = 1'b1; dp_valid = 1'b1; dp_byte = 8'h91;
        @(negedge clk); setup_stb = 1'b0; dp_valid = 1'b0;
        check("R4 strobe plus byte", int'(wr_valid), 1);
        send(2, 8'h92, 0);
        idle(2);

        // R1: sweep every format code on a 1x1 window
        for (int code = 0; code < 16; code++) begin
            set_cfg(code, 0, code % 4, 7, 9, 7, 9);
            strobe();
            check("R1 format byte count", int'(busy), (model_bpp(code) != 0) ? 1 : 0);
            send(4, code * 16, 0);
            idle(1);
        end
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule